// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits on a 32-bit host register bus and reaches a slow subsystem whose registers are 8 bits wide and 8-bit addressed. The host never addresses the subsystem directly. It writes a control word that holds the target address, the direction, the transfer size and the byte-lane enables. It then either waits, for a read, or supplies the data word, for a write. A busy flag in the control word tells the host when the far-side transfer has finished. The far side is modelled inside the block as a byte-wide memory whose response arrives a parameterised number of cycles after each request.

A transfer visits up to eight byte lanes in order. Lanes 0 to 3 belong to the lower data word. Lanes 4 to 7 belong to the upper data word and take part only when the size bit is set. Each enabled lane k accesses subsystem address base+k, modulo the address space. The block also holds two sticky interrupt flags: one for transfer completion and one for a level interrupt from the subsystem. Each flag is cleared by writing 1, and each has its own enable bit that gates a registered interrupt output.

Top module: `regbridge_top`

## Requirements
- R1: After reset the control, lower data, upper data, enable and flag registers read 0, `irq_out` is 0, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: The control word at 0x04 reads back as follows. Bit 31 is busy. Bit 25 is size (1 adds the upper lanes). Bit 24 is direction (1 means read). Bits 23:20 enable upper lanes 4 to 7. Bits 19:16 enable lower lanes 0 to 3. Bits 7:0 hold the subsystem base address. All other bits read 0.
- R3: A control write with direction 0 arms a write, and the next lower data write (0x08) launches it. For each enabled lane k, byte k of {upper data (0x0C), lower data} is stored at subsystem address base+k (mod 256).
- R4: A lower data write while no write is armed only stores the value. It starts no transfer, and busy stays 0. A launched transfer disarms.
- R5: A control write with direction 1 launches a read. Once busy has cleared, lower data byte k holds the byte read from base+k for each enabled lower lane and 0 for each disabled lane. When size is 1, upper data is filled the same way from lanes 4 to 7.
- R6: Busy reads 1 from the cycle after launch. It stays 1 for at least the far-side latency `LAT` per enabled lane, then clears by itself.
- R7: While busy, host writes to the control, lower data and upper data registers are ignored.
- R8: Flag register 0x14: bit 0 sets when a transfer completes, and bit 1 sets in every cycle `ss_irq` is high. Writing 1 to a bit clears it and writing 0 leaves it alone. A set condition wins over a clear in the same cycle.
- R9: `irq_out` is 1 exactly when some flag bit and the matching bit of the enable register 0x10 are both 1, with one register stage of delay.
- R10: Read data for `hst_rd` appears on `hst_rdata` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | HADDR_W | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| ss_irq | input | 1 | Subsystem interrupt level |
| irq_out | output | 1 | Masked interrupt output |

## Verification
The assertions take for granted that the host issues at most one access per cycle, either a write or a read. The far-side request and acknowledge checks also rely on the sequencer keeping at most one byte request outstanding. The stimulus keeps to this by driving one strobe at a time from sequential tasks. It polls busy through ordinary control reads before it starts each new transfer, except in the deliberate test that writes while busy. The ss_irq input is driven as a plain level with no timing relation to the transfers.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;
  localparam int OFF_ID   = 'h00;
  localparam int OFF_CTRL = 'h04;
  localparam int OFF_LDAT = 'h08;
  localparam int OFF_UDAT = 'h0C;
  localparam int OFF_IEN  = 'h10;
  localparam int OFF_IFLG = 'h14;

  localparam int BIT_BUSY = 31;
  localparam int BIT_SIZE = 25;
  localparam int BIT_DIR  = 24;
  localparam int BEN_LO   = 16;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PICK, SQ_WAIT} seq_state_t;
endpackage

// File: rtl/rb_far_bank.sv
module rb_far_bank #(
  parameter int AW  = 8,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          ack,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] dpipe [LAT];
  logic       vld [LAT];
  logic       outst;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
    dpipe[0] <= mem[addr];
    for (int i = 1; i < LAT; i++) dpipe[i] <= dpipe[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) vld[i] <= 1'b0;
      outst <= 1'b0;
    end else begin
      vld[0] <= req;
      for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
      if (req) outst <= 1'b1;
      else if (ack) outst <= 1'b0;
    end
  end

  assign ack   = vld[LAT-1];
  assign rdata = dpipe[LAT-1];

  // R6
  single_req_chk: assert property (@(posedge clk) disable iff (rst) req |-> !outst);
  // R6
  ack_pending_chk: assert property (@(posedge clk) disable iff (rst) ack |-> outst);
endmodule

// File: rtl/rb_xfer_seq.sv
module rb_xfer_seq
  import regbridge_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               dir_rd,
  input  logic               wide,
  input  logic [LANES-1:0]   ben,
  input  logic [AW-1:0]      base,
  input  logic [LANES*8-1:0] wdata,
  output logic               busy,
  output logic               done,
  output logic [LANES*8-1:0] rdata,
  output logic               mreq,
  output logic               mwe,
  output logic [AW-1:0]      maddr,
  output logic [7:0]         mwdata,
  input  logic               mack,
  input  logic [7:0]         mrdata
);
  localparam int LW   = $clog2(LANES);
  localparam int HALF = LANES / 2;
  localparam logic [LW-1:0] LAST = LW'(LANES - 1);

  seq_state_t         state;
  logic [LW-1:0]      lane;
  logic               dir_q, wide_q;
  logic [LANES-1:0]   ben_q;
  logic [AW-1:0]      base_q;
  logic [LANES*8-1:0] wdat_q;
  logic               lane_en;

  assign lane_en = ben_q[lane] && ((lane < LW'(HALF)) || wide_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      lane   <= '0;
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      ben_q  <= '0;
      base_q <= '0;
      wdat_q <= '0;
      rdata  <= '0;
      mreq   <= 1'b0;
      mwe    <= 1'b0;
      maddr  <= '0;
      mwdata <= '0;
    end else begin
      done <= 1'b0;
      mreq <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            dir_q  <= dir_rd;
            wide_q <= wide;
            ben_q  <= ben;
            base_q <= base;
            wdat_q <= wdata;
            rdata  <= '0;
            lane   <= '0;
            busy   <= 1'b1;
            state  <= SQ_PICK;
          end
        end
        SQ_PICK: begin
          if (lane_en) begin
            mreq   <= 1'b1;
            mwe    <= ~dir_q;
            maddr  <= base_q + AW'(lane);
            mwdata <= wdat_q[{lane, 3'b000} +: 8];
            state  <= SQ_WAIT;
          end else if (lane == LAST) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= SQ_IDLE;
          end else begin
            lane <= lane + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (mack) begin
            if (dir_q) rdata[{lane, 3'b000} +: 8] <= mrdata;
            if (lane == LAST) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= SQ_IDLE;
            end else begin
              lane  <= lane + 1'b1;
              state <= SQ_PICK;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));
endmodule

// File: rtl/rb_irq_flags.sv
module rb_irq_flags #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_clr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] set_in,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic [NSRC-1:0] clr_mask;

  assign clr_mask = wr_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_en) en <= wdata;
      flags <= (flags & ~clr_mask) | set_in;
      irq   <= |(flags & en);
    end
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst) set_in[0] |=> flags[0]);
  // R8
  level_set_chk: assert property (@(posedge clk) disable iff (rst) set_in[NSRC-1] |=> flags[NSRC-1]);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst) (en == '0) |=> !irq);
endmodule

// File: rtl/regbridge_top.sv
module regbridge_top
  import regbridge_pkg::*;
#(
  parameter int          HADDR_W  = 5,
  parameter int          FAR_AW   = 8,
  parameter int          LAT      = 3,
  parameter logic [31:0] ID_VALUE = 32'h5A1E_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_wr,
  input  logic               hst_rd,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [31:0]        hst_wdata,
  output logic [31:0]        hst_rdata,
  input  logic               ss_irq,
  output logic               irq_out
);
  localparam int LANES = 8;
  localparam logic [31:0] CTRL_MASK = 32'h03FF_0000 | 32'((1 << FAR_AW) - 1);

  logic [31:0] ctrl_q, ldat_q, udat_q;
  logic        armed_q;
  logic        busy, done;
  logic        sel_ctrl, sel_ldat, sel_udat, sel_ien, sel_iflg;
  logic        wr_ctrl, wr_ldat, wr_udat, start_rd, start_wr, start;
  logic [31:0] src_ctrl;
  logic [LANES*8-1:0] seq_rdata;
  logic [1:0]  ien, iflg;
  logic        mreq, mwe, mack;
  logic [FAR_AW-1:0] maddr;
  logic [7:0]  mwdata, mrdata;

  assign sel_ctrl = hst_addr == HADDR_W'(OFF_CTRL);
  assign sel_ldat = hst_addr == HADDR_W'(OFF_LDAT);
  assign sel_udat = hst_addr == HADDR_W'(OFF_UDAT);
  assign sel_ien  = hst_addr == HADDR_W'(OFF_IEN);
  assign sel_iflg = hst_addr == HADDR_W'(OFF_IFLG);

  assign wr_ctrl  = hst_wr && sel_ctrl && !busy;
  assign wr_ldat  = hst_wr && sel_ldat && !busy;
  assign wr_udat  = hst_wr && sel_udat && !busy;
  assign start_rd = wr_ctrl && hst_wdata[BIT_DIR];
  assign start_wr = wr_ldat && armed_q;
  assign start    = start_rd || start_wr;
  assign src_ctrl = start_rd ? (hst_wdata & CTRL_MASK) : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ldat_q  <= '0;
      udat_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (done && ctrl_q[BIT_DIR]) begin
        ldat_q <= seq_rdata[31:0];
        if (ctrl_q[BIT_SIZE]) udat_q <= seq_rdata[63:32];
      end
      if (wr_ctrl) begin
        ctrl_q  <= hst_wdata & CTRL_MASK;
        armed_q <= !hst_wdata[BIT_DIR];
      end
      if (wr_ldat) ldat_q <= hst_wdata;
      if (wr_udat) udat_q <= hst_wdata;
      if (start_wr) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_rd) begin
      case (1'b1)
        sel_ctrl: hst_rdata <= {busy, ctrl_q[30:0]};
        sel_ldat: hst_rdata <= ldat_q;
        sel_udat: hst_rdata <= udat_q;
        sel_ien:  hst_rdata <= {30'd0, ien};
        sel_iflg: hst_rdata <= {30'd0, iflg};
        default:  hst_rdata <= (hst_addr == HADDR_W'(OFF_ID)) ? ID_VALUE : 32'd0;
      endcase
    end
  end

  rb_xfer_seq #(.AW(FAR_AW), .LANES(LANES)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dir_rd (start_rd),
    .wide   (src_ctrl[BIT_SIZE]),
    .ben    (src_ctrl[BEN_LO +: LANES]),
    .base   (src_ctrl[FAR_AW-1:0]),
    .wdata  ({udat_q, hst_wdata}),
    .busy   (busy),
    .done   (done),
    .rdata  (seq_rdata),
    .mreq   (mreq),
    .mwe    (mwe),
    .maddr  (maddr),
    .mwdata (mwdata),
    .mack   (mack),
    .mrdata (mrdata)
  );

  rb_far_bank #(.AW(FAR_AW), .LAT(LAT)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .req   (mreq),
    .we    (mwe),
    .addr  (maddr),
    .wdata (mwdata),
    .ack   (mack),
    .rdata (mrdata)
  );

  rb_irq_flags #(.NSRC(2)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (hst_wr && sel_ien),
    .wr_clr (hst_wr && sel_iflg),
    .wdata  (hst_wdata[1:0]),
    .set_in ({ss_irq, done}),
    .en     (ien),
    .flags  (iflg),
    .irq    (irq_out)
  );

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && hst_wr && sel_ctrl) |=> $stable(ctrl_q));
  // R7
  ldat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && hst_wr && sel_ldat) |=> $stable(ldat_q));
  // R4
  no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && hst_wr && sel_ldat && !armed_q) |=> !busy);
endmodule

// File: tb/regbridge_top_test.sv
module regbridge_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam logic [31:0] IDV = 32'h5A1E_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 1'b0;
  logic        hst_rd = 1'b0;
  logic [4:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        ss_irq = 1'b0;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] q_exp [$];
  string       q_tag [$];
  bit          q_chk [$];
  logic        rd_seen = 1'b0;
  logic [7:0]  model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  regbridge_top #(.LAT(LAT), .ID_VALUE(IDV)) uut (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ss_irq(ss_irq), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one scoreboard item per completed host read
  always @(posedge clk) rd_seen <= hst_rd;
  always @(negedge clk) begin
    if (rd_seen && q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      bit c;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      c = q_chk.pop_front();
      if (c) check(hst_rdata === e, t, hst_rdata, e);
    end
  end

  task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic exp_read(input logic [4:0] a, input logic [31:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag); q_chk.push_back(1'b1);
    hst_rd = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    q_exp.push_back('0); q_tag.push_back(""); q_chk.push_back(1'b0);
    hst_rd = 1'b1; hst_addr = a;
    @(negedge clk);
    v = hst_rdata;
    hst_rd = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    peek(5'h04, v);
    while (v[31] && cyc < 2000) begin
      cyc++;
      peek(5'h04, v);
    end
    if (v[31]) check(1'b0, "R6 busy never cleared", v, 32'h0);
  endtask

  function automatic logic [31:0] mword(input logic [7:0] b);
    return {model[b + 8'd3], model[b + 8'd2], model[b + 8'd1], model[b]};
  endfunction

  initial begin
    logic [31:0] v;
    int cyc;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R10 registered read
    exp_read(5'h00, IDV, "R1/R10 id");
    exp_read(5'h04, 32'h0, "R1 ctrl");
    exp_read(5'h08, 32'h0, "R1 ldat");
    exp_read(5'h0C, 32'h0, "R1 udat");
    exp_read(5'h10, 32'h0, "R1 ien");
    exp_read(5'h14, 32'h0, "R1 iflg");
    check(irq_out === 1'b0, "R1 irq_out", {31'd0, irq_out}, 32'h0);

    // R3 narrow write of four lanes at 0x10
    host_wr(5'h04, 32'h000F_0010);
    exp_read(5'h04, 32'h000F_0010, "R2 ctrl armed");
    host_wr(5'h08, 32'h4433_2211);
    peek(5'h04, v);
    check(v[31] === 1'b1, "R6 busy after launch", v, 32'h800F_0010);
    wait_idle(cyc);
    check(cyc >= 4 * LAT, "R6 busy duration", cyc, 4 * LAT);
    model[8'h10] = 8'h11; model[8'h11] = 8'h22; model[8'h12] = 8'h33; model[8'h13] = 8'h44;
    exp_read(5'h14, 32'h1, "R8 done flag");
    host_wr(5'h14, 32'h1);
    exp_read(5'h14, 32'h0, "R8 w1c");

    // R5 full and partial reads
    host_wr(5'h04, 32'h010F_0010);
    wait_idle(cyc);
    exp_read(5'h08, mword(8'h10), "R5 read back");
    host_wr(5'h04, 32'h0105_0010);
    wait_idle(cyc);
    exp_read(5'h08, 32'h0033_0011, "R5 disabled lanes zero");

    // R3 wide write with address wrap, R4 upper write does not launch
    host_wr(5'h04, 32'h02F3_00FE);
    host_wr(5'h0C, 32'hDDCC_BBAA);
    peek(5'h04, v);
    check(v[31] === 1'b0, "R4 upper write no launch", v, 32'h02F3_00FE);
    host_wr(5'h08, 32'h0000_6655);
    wait_idle(cyc);
    model[8'hFE] = 8'h55; model[8'hFF] = 8'h66;
    model[8'h02] = 8'hAA; model[8'h03] = 8'hBB; model[8'h04] = 8'hCC; model[8'h05] = 8'hDD;
    host_wr(5'h04, 32'h03FF_00FE);
    wait_idle(cyc);
    exp_read(5'h08, mword(8'hFE), "R5 wide lower");
    exp_read(5'h0C, mword(8'h02), "R5 wide upper");
    host_wr(5'h14, 32'h3);

    // R4 lower write with nothing armed
    host_wr(5'h08, 32'h1234_5678);
    peek(5'h04, v);
    check(v[31] === 1'b0, "R4 no launch", v, 32'h0);
    exp_read(5'h08, 32'h1234_5678, "R4 value stored");
    host_wr(5'h04, 32'h010F_0010);
    wait_idle(cyc);
    exp_read(5'h08, mword(8'h10), "R4 far side untouched");

    // R7 writes during busy ignored
    host_wr(5'h04, 32'h010F_0010);
    host_wr(5'h04, 32'h000F_0020);
    host_wr(5'h08, 32'hAAAA_AAAA);
    host_wr(5'h0C, 32'hBBBB_BBBB);
    wait_idle(cyc);
    exp_read(5'h04, 32'h010F_0010, "R7 ctrl kept");
    exp_read(5'h08, mword(8'h10), "R7 ldat kept");
    exp_read(5'h0C, mword(8'h02), "R7 udat kept");

    // R8 / R9 flags and masking
    host_wr(5'h10, 32'h0);
    ss_irq = 1'b1;
    @(negedge clk);
    ss_irq = 1'b0;
    exp_read(5'h14, 32'h3, "R8 both flags");
    check(irq_out === 1'b0, "R9 masked", {31'd0, irq_out}, 32'h0);
    host_wr(5'h10, 32'h2);
    @(negedge clk);
    check(irq_out === 1'b1, "R9 enabled", {31'd0, irq_out}, 32'h1);
    host_wr(5'h14, 32'h1);
    exp_read(5'h14, 32'h2, "R8 zero bit no effect");
    host_wr(5'h14, 32'h2);
    exp_read(5'h14, 32'h0, "R8 cleared");
    @(negedge clk);
    check(irq_out === 1'b0, "R9 deasserts", {31'd0, irq_out}, 32'h0);
    ss_irq = 1'b1;
    host_wr(5'h14, 32'h2);
    exp_read(5'h14, 32'h2, "R8 set wins");
    ss_irq = 1'b0;
    @(negedge clk);
    host_wr(5'h14, 32'h3);
    host_wr(5'h10, 32'h0);

    // R2 reserved bits read zero while busy
    host_wr(5'h04, 32'hFFFF_FFFF);
    peek(5'h04, v);
    check(v === 32'h83FF_00FF, "R2 layout and busy", v, 32'h83FF_00FF);
    wait_idle(cyc);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule